// File: doc/BRIEF.md
# Frame Sync One-Shot Strobe Generator

This block turns a slow clock input into a frame sync line for a serial audio or data port. A second, faster signal serves as the pulse-width reference. In bypass mode the frame sync is a copy of the clock input, optionally inverted. In one-shot mode the block emits one pulse per clock-input period. That pulse is exactly one reference period wide and is placed on the second reference rising edge that follows the selected edge of the clock input.

The clock input, the reference and both control bits are asynchronous to the system clock. Each passes through a two-flop synchroniser. Edges are then detected on the system clock, so every output change comes three system-clock edges after the input change that caused it. The mode and invert bits are captured only when the synchronised clock input toggles, so a change of configuration takes effect on a clock-input transition and never part-way through a phase. The system clock must run at least four times faster than the reference, and each reference phase must last at least two system clocks.

Top module: `fsync_strobe_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, `fs_out` is 0 after that edge. Reset clears the edge counter and the stored configuration to bypass with no inversion.
- R2: With the stored configuration in bypass (`strobe_en` = 0) and invert = 0, `fs_out` equals `clk_in` as it was three `clk` edges earlier.
- R3: With the stored configuration in bypass and invert = 1, `fs_out` equals the complement of `clk_in` as it was three `clk` edges earlier.
- R4: In one-shot mode with invert = 0, a rising edge of `clk_in` arms the block. `fs_out` rises three `clk` edges after the second rising edge of `ref_in` that coincides with or follows that edge.
- R5: In one-shot mode with invert = 1, the same rule as R4 applies, but the arming edge is a falling edge of `clk_in`.
- R6: A one-shot pulse stays high for exactly one `ref_in` period, measured in `clk` cycles.
- R7: The reference edge that ends a pulse is not counted toward a new trigger. After a pulse the output stays low until the next arming edge, which gives one pulse per clock-input period.
- R8: An arming edge that arrives while the block is armed or pulsing ends any active pulse and restarts the count from zero. The pulse is never stretched.
- R9: A `ref_in` rising edge in the same cycle as the arming edge counts as the first reference edge.
- R10: `strobe_en` and `invert` are captured only at transitions of the synchronised `clk_in`. Changes between transitions have no effect on `fs_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the reference rate |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_in | input | 1 | Slow clock input, asynchronous |
| ref_in | input | 1 | Pulse-width reference signal, asynchronous |
| strobe_en | input | 1 | 1 selects one-shot mode, 0 selects bypass |
| invert | input | 1 | Selects the inverted polarity / falling-edge arming |
| fs_out | output | 1 | Frame sync output |

## Verification
The hardest situations to reach are the collisions: an arming edge that lands on a reference rising edge, and an arming edge that lands while a pulse is armed or already high. Free-running stimulus rarely lines these up. Directed segments therefore start both waveform counters at phase zero, with the clock half-period a whole multiple of the reference period, so coincidences repeat every period. Further segments use a clock half-period shorter than two reference periods, which forces restarts. Random segments also change the control bits between clock-input transitions, which exercises the capture rule.

// File: rtl/fsg_pkg.sv
// Shared types for the frame sync strobe generator.
package fsg_pkg;

    // One-shot sequencer state
    typedef enum logic [1:0] {
        OS_IDLE = 2'd0,
        OS_ARM  = 2'd1,
        OS_FIRE = 2'd2
    } os_state_t;

    // Configuration captured at clock-input transitions
    typedef struct packed {
        logic strobe;
        logic inv;
    } fsg_cfg_t;

endpackage

// File: rtl/fsg_sync.sv
// Multi-bit synchroniser: each bit passes through STAGES flops on clk.
// Assumes the bits are independent, slowly changing signals; no bus
// coherence is implied between bits.
module fsg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/fsg_edge.sv
// Edge detector for already-synchronised signals: one flop of history per
// channel, rise/fall valid for one clk cycle. Assumes din is synchronous.
module fsg_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] prev;

    // Remember last cycle's level of each channel
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= din;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_ch
        assign rise[g] = din[g] & ~prev[g];
        assign fall[g] = ~din[g] & prev[g];
    end

endmodule

// File: rtl/fsg_oneshot.sv
// One-shot sequencer: an arming edge starts counting reference rising
// edges; on edge number FIRE_EDGE the pulse starts, and the following
// reference rising edge ends it. An arming edge always restarts the count.
// Assumes arm and ref_rise are single-cycle strobes on clk.
module fsg_oneshot
    import fsg_pkg::*;
#(
    parameter int FIRE_EDGE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic arm,
    input  logic ref_rise,
    output logic pulse_nxt
);

    localparam int CW = $clog2(FIRE_EDGE + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(FIRE_EDGE - 1);

    os_state_t       st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // Next-state decision for the edge counter and pulse phase
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!enable) begin
            st_d  = OS_IDLE;
            cnt_d = '0;
        end else if (arm) begin
            if (ref_rise && (FIRE_EDGE == 1)) begin
                st_d  = OS_FIRE;
                cnt_d = '0;
            end else begin
                st_d  = OS_ARM;
                cnt_d = ref_rise ? CW'(1) : '0;
            end
        end else if (ref_rise) begin
            unique case (st_q)
                OS_ARM: begin
                    if (cnt_q == LAST_CNT) begin
                        st_d  = OS_FIRE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                OS_FIRE: st_d = OS_IDLE;
                default: st_d = OS_IDLE;
            endcase
        end
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= OS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign pulse_nxt = (st_d == OS_FIRE);

endmodule

// File: rtl/fsync_strobe_gen.sv
// Frame sync generator top. Synchronises clock input, reference and the
// two control bits, captures configuration at clock-input transitions and
// drives a registered frame sync: either the (optionally inverted) clock
// input or a one-shot pulse one reference period wide. Assumes clk is at
// least four times the reference rate.
module fsync_strobe_gen
    import fsg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FIRE_EDGE   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_in,
    input  logic ref_in,
    input  logic strobe_en,
    input  logic invert,
    output logic fs_out
);

    localparam int NSIG   = 4;
    localparam int I_CLK  = 0;
    localparam int I_REF  = 1;
    localparam int I_STB  = 2;
    localparam int I_INV  = 3;
    localparam int NEDGE  = 2;

    logic [NSIG-1:0]  raw_in, syn_in;
    logic [NEDGE-1:0] e_rise, e_fall;
    logic             ci_s, ref_rise, ci_edge, arm, pulse_nxt;
    fsg_cfg_t         cfg_q, cfg_nxt, cfg_s;
    logic             fs_q;
    logic             unused_ref_fall;

    assign raw_in[I_CLK] = clk_in;
    assign raw_in[I_REF] = ref_in;
    assign raw_in[I_STB] = strobe_en;
    assign raw_in[I_INV] = invert;

    fsg_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (syn_in)
    );

    fsg_edge #(.WIDTH(NEDGE)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({syn_in[I_REF], syn_in[I_CLK]}),
        .rise  (e_rise),
        .fall  (e_fall)
    );

    assign ci_s            = syn_in[I_CLK];
    assign ci_edge         = e_rise[0] | e_fall[0];
    assign ref_rise        = e_rise[1];
    assign unused_ref_fall = e_fall[1];
    assign cfg_s.strobe    = syn_in[I_STB];
    assign cfg_s.inv       = syn_in[I_INV];

    // Configuration in force this cycle: new value only on a clock-input transition
    always_comb begin
        cfg_nxt = ci_edge ? cfg_s : cfg_q;
    end

    // Qualifying edge for the one-shot, chosen by the polarity in force
    assign arm = cfg_nxt.strobe & (cfg_nxt.inv ? e_fall[0] : e_rise[0]);

    fsg_oneshot #(.FIRE_EDGE(FIRE_EDGE)) u_os (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_nxt.strobe),
        .arm       (arm),
        .ref_rise  (ref_rise),
        .pulse_nxt (pulse_nxt)
    );

    // Hold the captured configuration and register the frame sync output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            fs_q  <= 1'b0;
        end else begin
            cfg_q <= cfg_nxt;
            fs_q  <= cfg_nxt.strobe ? pulse_nxt : (ci_s ^ cfg_nxt.inv);
        end
    end

    assign fs_out = fs_q;

endmodule

// File: rtl/fsg_checker.sv
// Property checker for fsync_strobe_gen, attached by bind below.
module fsg_checker (
    input logic clk,
    input logic rst_n,
    input logic fs_out,
    input logic ci_s,
    input logic ci_edge,
    input logic ref_rise,
    input logic se_q,
    input logic iv_q,
    input logic se_nxt,
    input logic iv_nxt
);

    // R2 R3
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !se_nxt |=> (fs_out == ($past(ci_s) ^ $past(iv_nxt))));

    // R4
    rise_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fs_out) && se_q) |-> $past(ref_rise));

    // R7
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fs_out) && se_q) |-> ($past(ref_rise) || $past(ci_edge)));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ci_edge |=> $stable({se_q, iv_q}));

endmodule

bind fsync_strobe_gen fsg_checker u_fsg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs_out   (fs_out),
    .ci_s     (ci_s),
    .ci_edge  (ci_edge),
    .ref_rise (ref_rise),
    .se_q     (cfg_q.strobe),
    .iv_q     (cfg_q.inv),
    .se_nxt   (cfg_nxt.strobe),
    .iv_nxt   (cfg_nxt.inv)
);

// File: tb/fsync_strobe_gen_test.sv
module fsync_strobe_gen_test;

    localparam int LAT       = 3;
    localparam int RING      = 8;
    localparam int MAX_CYC   = 150000;
    localparam int A_STB_BIT = 0;
    localparam int A_INV_BIT = 1;
    localparam int B_STB_BIT = 16;
    localparam int B_INV_BIT = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_in = 1'b0, ref_in = 1'b0, strobe_en = 1'b0, invert = 1'b0;
    logic fs_out;

    fsync_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .clk_in(clk_in), .ref_in(ref_in),
        .strobe_en(strobe_en), .invert(invert), .fs_out(fs_out)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0, prints = 0;
    bit check_en = 0, done = 0;

    // expected output ring, indexed by cycle of observation
    bit ring_e [RING];
    int ring_t [RING];
    int ring_w [RING];
    bit ring_c [RING];
    int ring_s [RING];

    // bench model state (from the requirements)
    bit m_cp, m_rp, m_se, m_iv, m_cnt;
    int m_st, m_tag;
    int cur_rp = 4, seg = 0;
    bit clean = 0, unit_b = 0;

    function automatic bit [31:0] ctl_word(bit ub, bit se, bit iv);
        bit [31:0] w = '0;
        if (ub) begin w[B_STB_BIT] = se; w[B_INV_BIT] = iv; end
        else    begin w[A_STB_BIT] = se; w[A_INV_BIT] = iv; end
        return w;
    endfunction

    function automatic void model_clear();
        m_cp = 0; m_rp = 0; m_se = 0; m_iv = 0; m_cnt = 0; m_st = 0; m_tag = 1;
    endfunction

    task automatic report(bit ok, int tag, int act, int exp_v, string what);
        total++;
        if (!ok) begin
            bad++;
            if (prints < 30) $display("FAIL R%0d %s at cycle %0d: actual=%0d expected=%0d",
                                      tag, what, cyc, act, exp_v);
            prints++;
        end
    endtask

    // One system-clock step: drive inputs and predict the output LAT edges later
    task automatic drive_cycle(bit ci, bit rf, bit se, bit iv);
        int n, tg;
        bit e, edg, q, rr, ch_ctl;
        bit [31:0] w;
        @(negedge clk);
        n = cyc;
        w = ctl_word(unit_b, se, iv);
        clk_in    = ci;
        ref_in    = rf;
        strobe_en = unit_b ? w[B_STB_BIT] : w[A_STB_BIT];
        invert    = unit_b ? w[B_INV_BIT] : w[A_INV_BIT];
        edg = (ci != m_cp);
        rr  = rf && !m_rp;
        if (edg) begin
            if (se && !m_se) m_tag = iv ? 5 : 4;
            m_se = se; m_iv = iv;
        end
        ch_ctl = !edg && ((se != m_se) || (iv != m_iv));
        if (!m_se) begin
            m_st = 0; m_cnt = 0;
            e  = ci ^ m_iv;
            tg = m_iv ? 3 : 2;                 // R2 / R3
        end else begin
            q = edg && (m_iv ? !ci : ci);
            if (q) begin
                // R8 restart, R9 coincident edge, else R4 / R5
                m_tag = (m_st != 0) ? 8 : (rr ? 9 : (m_iv ? 5 : 4));
                m_st  = 1;
                m_cnt = rr;
            end else if (rr) begin
                if (m_st == 1) begin
                    if (m_cnt) m_st = 2; else m_cnt = 1;
                end else if (m_st == 2) begin
                    m_st = 0; m_tag = 7;           // R7 end edge not recounted
                end
            end
            e  = (m_st == 2);
            tg = m_tag;
        end
        if (ch_ctl) tg = 10;                       // R10
        m_cp = ci; m_rp = rf;
        ring_e[(n+LAT)%RING] = e;
        ring_t[(n+LAT)%RING] = tg;
        ring_w[(n+LAT)%RING] = cur_rp;
        ring_c[(n+LAT)%RING] = clean && m_se;
        ring_s[(n+LAT)%RING] = seg;
    endtask

    // Per-cycle comparison and pulse-width measurement
    bit prev_fs = 0, rise_ok = 0;
    int rise_m = 0, rise_seg = 0, w_exp = 0;
    always @(negedge clk) begin
        if (check_en && !done) begin
            int idx;
            idx = cyc % RING;
            report(fs_out === ring_e[idx], ring_t[idx], fs_out, ring_e[idx], "fs_out");
            if (fs_out && !prev_fs) begin
                rise_m = cyc; rise_ok = ring_c[idx]; rise_seg = ring_s[idx]; w_exp = ring_w[idx];
            end
            if (!fs_out && prev_fs && rise_ok && ring_c[idx] && ring_s[idx] == rise_seg)
                report((cyc - rise_m) == w_exp, 6, cyc - rise_m, w_exp, "pulse width"); // R6
            prev_fs = fs_out;
        end
    end

    // R1: reset with inputs still moving
    task automatic do_reset(int len);
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        for (int i = 0; i < RING; i++) begin
            ring_e[i] = 0; ring_t[i] = 1; ring_c[i] = 0; ring_s[i] = -1;
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            clk_in = $urandom % 2; ref_in = $urandom % 2;
            strobe_en = $urandom % 2; invert = $urandom % 2;
            ring_e[(cyc+LAT)%RING] = 0; ring_t[(cyc+LAT)%RING] = 1;
            ring_c[(cyc+LAT)%RING] = 0;
            check_en = 1;
        end
        clk_in = 0; ref_in = 0; strobe_en = 0; invert = 0;
        rst_n = 1'b1;
        model_clear();
        report(fs_out === 1'b0, 1, fs_out, 0, "reset level");
    endtask

    task automatic run_seg(int rp, int ch, bit se, bit iv, int len, bit align, bit jitter);
        int rc, cc;
        bit s, v;
        seg++;
        cur_rp = rp;
        clean  = (ch >= 4*rp) && !jitter;
        rc = align ? 0 : $urandom % rp;
        cc = align ? 0 : $urandom % (2*ch);
        s = se; v = iv;
        for (int i = 0; i < len; i++) begin
            if (jitter && (i % 23 == 11)) begin s = $urandom % 2; v = $urandom % 2; end
            drive_cycle(cc < ch, rc < rp/2, s, v);
            rc = (rc + 1) % rp;
            cc = (cc + 1) % (2*ch);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0f5));
        model_clear();
        repeat (2) @(negedge clk);
        do_reset(4);
        // R2, R3: bypass both polarities
        run_seg(6, 20, 0, 0, 400, 0, 0);
        run_seg(6, 13, 0, 1, 400, 0, 0);
        // R4, R5, R6: clean one-shot, both polarities, both control-word units
        run_seg(7, 40, 1, 0, 800, 0, 0);
        unit_b = 1;
        run_seg(7, 40, 1, 1, 800, 0, 0);
        run_seg(4, 30, 1, 0, 600, 0, 0);
        // R9: aligned, clock half-period a multiple of the reference period
        run_seg(5, 15, 1, 0, 600, 1, 0);
        run_seg(5, 20, 1, 1, 600, 1, 0);
        unit_b = 0;
        // R8: arming faster than two reference periods
        run_seg(8, 6, 1, 0, 500, 0, 0);
        run_seg(9, 7, 1, 1, 500, 0, 0);
        // R10: clock input held, controls toggled between transitions
        run_seg(6, 2000, 0, 0, 300, 0, 1);
        run_seg(6, 2000, 1, 1, 300, 0, 1);
        // R1: reset in the middle of activity
        run_seg(6, 30, 1, 0, 200, 0, 0);
        do_reset(3);
        // R7 and mixed: random segments
        for (int k = 0; k < 30; k++) begin
            int rp, ch;
            rp = 4 + $urandom % 7;
            ch = 2 + $urandom % 50;
            unit_b = $urandom % 2;
            run_seg(rp, ch, $urandom % 2, $urandom % 2, 250 + $urandom % 250,
                    ($urandom % 4) == 0, ($urandom % 3) == 0);
        end
        repeat (LAT + 1) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #(MAX_CYC * 10);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", cyc, MAX_CYC);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule